// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block holds the interrupt flag register, the interrupt enable register and a per-cause error register of an SD/MMC host controller. Event logic elsewhere in the host sends single-cycle pulses (command response finished, data finished, FIFO overflow or underrun, receive ready, transmit request, illegal command access). It also sends a pulse for each detailed error cause. The block latches these into sticky flags, groups the detailed causes into summary flags, and raises one interrupt line whenever an enabled flag is pending. It also watches two card-detect levels and one write-protect level. It turns the card-detect edges into insert and remove events and shows all three levels live in the status word.

Software reads and writes three 32-bit registers through a plain register port with a 2-bit address: status at 0, interrupt disable at 1, error detail at 2. Address 3 reads as zero. A flag is cleared by writing 0 to its bit. A level-sensitive soft-reset input clears every sticky flag and every error-detail bit. It does not touch the disable register.

Top module: `sdhost_irq_ctl`

## Requirements
- R1: A write to address 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A read of address 0 returns 1 for every pending flag.
- R2: The disable register at address 1 resets to 32'h8B7F031D. Only the bits set in that value can be written; every other bit reads 0.
- R3: `irqOut` is high exactly when at least one pending flag has its disable bit at 0. A disable bit at 1 keeps its flag from reaching `irqOut`.
- R4: The pulse inputs set these status bits: response end bit 0, data end bit 2, RX overflow bit 20, TX underrun bit 21, RX ready bit 24, TX request bit 25, spare event bit 27, illegal access bit 31. Each flag reads 1 on the cycle after the pulse.
- R5: A low-to-high change of `cardPresent` sets bit 4 and a high-to-low change sets bit 3. Bit 5 always shows `cardPresent` and bit 7 always shows `wrProtect`.
- R6: A high-to-low change of `dat3Level` sets bit 8 and a low-to-high change sets bit 9. Bit 10 always shows `dat3Level`.
- R7: Each `errEvt[i]` pulse sets bit i of the error-detail register at address 2. Writing 0 to a detail bit clears it, and writing 1 leaves it unchanged.
- R8: Error causes roll up into summary status flags. errEvt 0..3 (response CRC, stop-command response CRC, read CRC, write CRC status) set bit 17. errEvt 4..7 (the matching end-bit errors) set bit 18. errEvt 8..10 (busy timeout, CRC-status timeout, start-bit timeout) set bit 19. errEvt 11..12 (response timeouts) set bit 22. errEvt 13..14 (bad command index) set bit 16. Clearing a summary flag leaves the detail bits intact.
- R9: When a set pulse and a clearing write reach the same flag in the same cycle, the flag reads 1 afterwards.
- R10: While `softRstN` is 0, all sticky status flags and all detail bits read 0 and incoming pulses are dropped. The disable register keeps its value.
- R11: Status bit 23 always reads 1. Status bits 1, 6, 11 to 15, 26, 28, 29 and 30 always read 0. Address 3 reads 0.
- R12: Levels already present on `cardPresent` or `dat3Level` when `rst_n` is released produce no edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softRstN | input | 1 | Soft reset level, 0 clears flags and detail |
| regAddr | input | 2 | Register select: 0 status, 1 disable, 2 detail |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| evtRespEnd | input | 1 | Response end pulse |
| evtDataEnd | input | 1 | Data end pulse |
| evtRxOverflow | input | 1 | RX overflow pulse |
| evtTxUnderrun | input | 1 | TX underrun pulse |
| evtRxReady | input | 1 | RX ready pulse |
| evtTxRequest | input | 1 | TX request pulse |
| evtSpare | input | 1 | Spare maskable event pulse |
| evtIllegal | input | 1 | Illegal command access pulse |
| errEvt | input | 15 | Per-cause error pulses |
| cardPresent | input | 1 | Card-present switch level |
| wrProtect | input | 1 | Write-protect switch level |
| dat3Level | input | 1 | DATA3 card-detect level |
| irqOut | output | 1 | Interrupt request |

## Verification
A hardware set pulse and a software clearing write can reach the same flag in the same cycle. The bench provokes this by raising the response-end pulse during the same cycle as a status write of all zeros. It then requires bit 0 to still read 1 while the other flags are gone. The second overlap is a soft reset held over a pulse on both an event input and an error input. Here the clear must win, so the status reads only its live and constant bits and the detail reads zero.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int REG_W    = 32;
  localparam int DETAIL_W = 15;
  localparam int ADDR_W   = 2;

  localparam logic [REG_W-1:0] ACK_BITS  = 32'h8B7F_031D;
  localparam logic [REG_W-1:0] CONST_ONE = 32'h0080_0000;

  localparam int B_RESP    = 0;
  localparam int B_DATA    = 2;
  localparam int B_REMOVE  = 3;
  localparam int B_INSERT  = 4;
  localparam int B_PRESENT = 5;
  localparam int B_WP      = 7;
  localparam int B_D3FALL  = 8;
  localparam int B_D3RISE  = 9;
  localparam int B_D3LVL   = 10;
  localparam int B_IDX     = 16;
  localparam int B_CRC     = 17;
  localparam int B_ENDBIT  = 18;
  localparam int B_DTO     = 19;
  localparam int B_OVF     = 20;
  localparam int B_UNF     = 21;
  localparam int B_CTO     = 22;
  localparam int B_RXRDY   = 24;
  localparam int B_TXREQ   = 25;
  localparam int B_SPARE   = 27;
  localparam int B_ILL     = 31;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_DETAIL = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic wrDetail;
    logic clrAll;
  } strobe_t;

  // Summary status bit fed by detail cause idx
  function automatic int summaryBit(input int idx);
    if (idx < 4)       return B_CRC;
    else if (idx < 8)  return B_ENDBIT;
    else if (idx < 11) return B_DTO;
    else if (idx < 13) return B_CTO;
    else               return B_IDX;
  endfunction
endpackage

// File: rtl/sdirq_edge.sv
module sdirq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prevQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevQ <= 1'b0;
    else        prevQ <= level;
  end

  assign rise = arm & level & ~prevQ;
  assign fall = arm & ~level & prevQ;
endmodule

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
  import sdirq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              softRstN,
  output strobe_t           strb,
  output regSel_e           rdSel
);
  always_comb begin
    rdSel         = regSel_e'(regAddr);
    strb          = '0;
    strb.clrAll   = ~softRstN;
    strb.wrStatus = regWrEn && (rdSel == SEL_STATUS);
    strb.wrMask   = regWrEn && (rdSel == SEL_MASK);
    strb.wrDetail = regWrEn && (rdSel == SEL_DETAIL);
  end
endmodule

// File: rtl/sdirq_dpath.sv
module sdirq_dpath
  import sdirq_pkg::*;
#(
  parameter int DW = DETAIL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  regSel_e          rdSel,
  input  logic [REG_W-1:0] wrData,
  input  logic             evtRespEnd,
  input  logic             evtDataEnd,
  input  logic             evtRxOverflow,
  input  logic             evtTxUnderrun,
  input  logic             evtRxReady,
  input  logic             evtTxRequest,
  input  logic             evtSpare,
  input  logic             evtIllegal,
  input  logic [DW-1:0]    errEvt,
  input  logic             cardPresent,
  input  logic             wrProtect,
  input  logic             dat3Level,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] statusView,
  output logic [REG_W-1:0] maskView,
  output logic             irqOut
);
  localparam int NUM_LINES = 2;

  logic [REG_W-1:0] flagQ, maskQ, setVec, rollup, keepVec, liveVec;
  logic [DW-1:0]    detailQ, keepDet;
  logic             armQ;
  logic [NUM_LINES-1:0] lineLvl, lineRise, lineFall;

  assign lineLvl = {dat3Level, cardPresent};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armQ <= 1'b0;
    else        armQ <= 1'b1;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_edge
    sdirq_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (armQ),
      .level(lineLvl[g]),
      .rise (lineRise[g]),
      .fall (lineFall[g])
    );
  end

  always_comb begin
    rollup = '0;
    for (int i = 0; i < DW; i++)
      if (errEvt[i]) rollup[summaryBit(i)] = 1'b1;
  end

  always_comb begin
    setVec           = rollup;
    setVec[B_RESP]   = evtRespEnd;
    setVec[B_DATA]   = evtDataEnd;
    setVec[B_OVF]    = evtRxOverflow;
    setVec[B_UNF]    = evtTxUnderrun;
    setVec[B_RXRDY]  = evtRxReady;
    setVec[B_TXREQ]  = evtTxRequest;
    setVec[B_SPARE]  = evtSpare;
    setVec[B_ILL]    = evtIllegal;
    setVec[B_INSERT] = lineRise[0];
    setVec[B_REMOVE] = lineFall[0];
    setVec[B_D3RISE] = lineRise[1];
    setVec[B_D3FALL] = lineFall[1];
    setVec           = setVec & ACK_BITS;
  end

  assign keepVec = strb.wrStatus ? wrData : '1;
  assign keepDet = strb.wrDetail ? wrData[DW-1:0] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flagQ <= '0;
    else if (strb.clrAll) flagQ <= '0;
    else                  flagQ <= ((flagQ & keepVec) | setVec) & ACK_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           detailQ <= '0;
    else if (strb.clrAll) detailQ <= '0;
    else                  detailQ <= (detailQ & keepDet) | errEvt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           maskQ <= ACK_BITS;
    else if (strb.wrMask) maskQ <= wrData & ACK_BITS;
  end

  always_comb begin
    liveVec            = CONST_ONE;
    liveVec[B_PRESENT] = cardPresent;
    liveVec[B_WP]      = wrProtect;
    liveVec[B_D3LVL]   = dat3Level;
  end

  assign statusView = flagQ | liveVec;
  assign maskView   = maskQ;
  assign irqOut     = |(flagQ & ~maskQ);

  always_comb begin
    unique case (rdSel)
      SEL_STATUS: rdData = statusView;
      SEL_MASK:   rdData = maskQ;
      SEL_DETAIL: rdData = REG_W'(detailQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/sdhost_irq_ctl.sv
module sdhost_irq_ctl
  import sdirq_pkg::*;
#(
  parameter int DW = DETAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              evtRespEnd,
  input  logic              evtDataEnd,
  input  logic              evtRxOverflow,
  input  logic              evtTxUnderrun,
  input  logic              evtRxReady,
  input  logic              evtTxRequest,
  input  logic              evtSpare,
  input  logic              evtIllegal,
  input  logic [DW-1:0]     errEvt,
  input  logic              cardPresent,
  input  logic              wrProtect,
  input  logic              dat3Level,
  output logic              irqOut
);
  strobe_t          strb;
  regSel_e          rdSel;
  logic [REG_W-1:0] statusVal, maskVal;

  sdirq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .softRstN(softRstN),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  sdirq_dpath #(.DW(DW)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .rdSel        (rdSel),
    .wrData       (regWrData),
    .evtRespEnd   (evtRespEnd),
    .evtDataEnd   (evtDataEnd),
    .evtRxOverflow(evtRxOverflow),
    .evtTxUnderrun(evtTxUnderrun),
    .evtRxReady   (evtRxReady),
    .evtTxRequest (evtTxRequest),
    .evtSpare     (evtSpare),
    .evtIllegal   (evtIllegal),
    .errEvt       (errEvt),
    .cardPresent  (cardPresent),
    .wrProtect    (wrProtect),
    .dat3Level    (dat3Level),
    .rdData       (regRdData),
    .statusView   (statusVal),
    .maskView     (maskVal),
    .irqOut       (irqOut)
  );
endmodule

// File: rtl/sdhost_irq_chk.sv
module sdhost_irq_chk
  import sdirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              softRstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic              evtRespEnd,
  input logic              evtDataEnd,
  input logic              cardPresent,
  input logic              wrProtect,
  input logic              dat3Level,
  input logic [REG_W-1:0]  statusVal,
  input logic [REG_W-1:0]  maskVal,
  input logic              irqOut
);
  localparam logic [REG_W-1:0] LIVE_BITS = 32'h0000_04A0;

  a_r1_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (softRstN && regWrEn && regAddr == 2'd0 && !regWrData[B_DATA] && !evtDataEnd)
      |=> !statusVal[B_DATA]);

  a_r2_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (maskVal & ~ACK_BITS) == '0);

  a_r3_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusVal & ~maskVal & ACK_BITS) == '0) |-> !irqOut);

  a_r5_live_levels: assert property (@(posedge clk) disable iff (!rst_n)
    statusVal[B_PRESENT] == cardPresent && statusVal[B_WP] == wrProtect
      && statusVal[B_D3LVL] == dat3Level);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (softRstN && evtRespEnd) |=> statusVal[B_RESP]);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !softRstN |=> ((statusVal & ACK_BITS) == '0));

  a_r11_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    statusVal[23] && ((statusVal & ~(ACK_BITS | LIVE_BITS | CONST_ONE)) == '0));
endmodule

bind sdhost_irq_ctl sdhost_irq_chk chk_i (.*);

// File: tb/sdhost_irq_ctl_tb.sv
module sdhost_irq_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        softRstN = 1'b1;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evtRespEnd = 0, evtDataEnd = 0, evtRxOverflow = 0, evtTxUnderrun = 0;
  logic        evtRxReady = 0, evtTxRequest = 0, evtSpare = 0, evtIllegal = 0;
  logic [14:0] errEvt = '0;
  logic        cardPresent = 0, wrProtect = 0, dat3Level = 0;
  logic        irqOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdhost_irq_ctl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] base();
    return 32'h0080_0000 | (32'(cardPresent) << 5) | (32'(wrProtect) << 7)
           | (32'(dat3Level) << 10);
  endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseNamed(input int k);
    case (k)
      0: evtRespEnd = 1; 1: evtDataEnd = 1; 2: evtRxOverflow = 1; 3: evtTxUnderrun = 1;
      4: evtRxReady = 1; 5: evtTxRequest = 1; 6: evtSpare = 1; default: evtIllegal = 1;
    endcase
    @(negedge clk);
    {evtRespEnd, evtDataEnd, evtRxOverflow, evtTxUnderrun} = '0;
    {evtRxReady, evtTxRequest, evtSpare, evtIllegal} = '0;
  endtask

  function automatic int grp(input int i);
    if (i <= 3) return 17;
    if (i <= 7) return 18;
    if (i <= 10) return 19;
    if (i <= 12) return 22;
    return 16;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R11 status after reset", d, 32'h0080_0000);
    rd(2'd1, d); chk("R2 mask after reset", d, 32'h8B7F_031D);
    rd(2'd2, d); chk("R7 detail after reset", d, 32'h0);
    rd(2'd3, d); chk("R11 address 3 reads zero", d, 32'h0);
    chk("R3 irq idle after reset", 32'(irqOut), 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    int pos [8] = '{0, 2, 20, 21, 24, 25, 27, 31};
    for (int k = 0; k < 8; k++) begin
      pulseNamed(k);
      rd(2'd0, d); chk($sformatf("R4 event %0d sets bit %0d", k, pos[k]), d, base() | (32'h1 << pos[k]));
      wr(2'd0, 32'h0);
    end
  endtask

  task automatic t_ack();
    logic [31:0] d;
    evtRespEnd = 1; evtDataEnd = 1; @(negedge clk); evtRespEnd = 0; evtDataEnd = 0;
    wr(2'd0, ~32'h1);
    rd(2'd0, d); chk("R1 write 0 clears only bit0", d, base() | 32'h4);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R1 write 1 keeps flag", d, base() | 32'h4);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulseNamed(0);
    chk("R3 disabled flag gives no irq", 32'(irqOut), 32'h0);
    wr(2'd1, ~32'h1);
    chk("R3 enabled flag raises irq", 32'(irqOut), 32'h1);
    wr(2'd1, ~32'h4);
    chk("R3 other source enabled, no irq", 32'(irqOut), 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0);
    chk("R3 irq drops after ack", 32'(irqOut), 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R2 only maskable bits stored", d, 32'h8B7F_031D);
  endtask

  task automatic t_card();
    logic [31:0] d;
    cardPresent = 1; wrProtect = 1; @(negedge clk);
    rd(2'd0, d); chk("R5 insert edge and live bits", d, base() | 32'h10);
    wr(2'd0, 32'h0);
    cardPresent = 0; @(negedge clk);
    rd(2'd0, d); chk("R5 remove edge", d, base() | 32'h8);
    wr(2'd0, 32'h0);
    dat3Level = 1; @(negedge clk);
    rd(2'd0, d); chk("R6 DATA3 rise", d, base() | 32'h200);
    wr(2'd0, 32'h0);
    dat3Level = 0; wrProtect = 0; @(negedge clk);
    rd(2'd0, d); chk("R6 DATA3 fall", d, base() | 32'h100);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_detail();
    logic [31:0] d;
    for (int i = 0; i < 15; i++) begin
      errEvt[i] = 1'b1; @(negedge clk); errEvt = '0;
      rd(2'd2, d); chk($sformatf("R7 detail bit %0d", i), d, 32'h1 << i);
      rd(2'd0, d); chk($sformatf("R8 cause %0d summary", i), d, base() | (32'h1 << grp(i)));
      wr(2'd0, 32'h0);
      rd(2'd2, d); chk("R8 summary ack keeps detail", d, 32'h1 << i);
      wr(2'd2, 32'h0);
      rd(2'd2, d); chk("R7 detail cleared by 0", d, 32'h0);
    end
  endtask

  task automatic t_collide();
    logic [31:0] d;
    evtDataEnd = 1; @(negedge clk); evtDataEnd = 0;
    evtRespEnd = 1; regAddr = 2'd0; regWrData = 32'h0; regWrEn = 1;
    @(negedge clk);
    evtRespEnd = 0; regWrEn = 0;
    rd(2'd0, d); chk("R9 set beats same-cycle ack", d, base() | 32'h1);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(2'd1, 32'h0000_0004);
    pulseNamed(1); errEvt[3] = 1; @(negedge clk); errEvt = '0;
    softRstN = 0; evtRespEnd = 1; errEvt[0] = 1; @(negedge clk);
    evtRespEnd = 0; errEvt = '0;
    rd(2'd0, d); chk("R10 soft reset clears flags", d, base());
    rd(2'd2, d); chk("R10 soft reset clears detail", d, 32'h0);
    rd(2'd1, d); chk("R10 mask kept", d, 32'h0000_0004);
    softRstN = 1; @(negedge clk);
    rd(2'd0, d); chk("R10 nothing latched after release", d, base());
  endtask

  task automatic t_reset_levels();
    logic [31:0] d;
    rst_n = 0; cardPresent = 1; dat3Level = 1; @(negedge clk);
    rst_n = 1; @(negedge clk); @(negedge clk);
    rd(2'd0, d); chk("R12 no edge flags from reset levels", d, base());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_ack();
    t_irq();
    t_card();
    t_detail();
    t_collide();
    t_soft();
    t_reset_levels();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule